// File: doc/BRIEF.md
# Audio DMA Channel Register Block

This block holds the control and status registers for a bus-master audio DMA engine that has three channels: capture, playback and microphone. Each channel has the following state:

- a base address for its list of 8-byte buffer descriptors;
- a current descriptor index, a prefetched descriptor index and a last valid descriptor index;
- a position-in-buffer count;
- a five-bit status register;
- a five-bit control register.

Software reaches the registers over a simple byte-addressed bus. The bus carries right-justified write and read data and a size code: 0 is a byte, 1 is a 16-bit half and 2 is a 32-bit word. Read data is combinational in the cycle the request is presented. Writes take effect at the clock edge that samples them.

A DMA sequencer sits beside the block. It pulses per-channel strobes to tell the block about events: advance to the next descriptor, buffer complete, last valid buffer reached, and FIFO error. With the buffer-complete strobe it also supplies the completion-interrupt flag, which is bit 31 of the completing descriptor's control word. It loads the position count as it consumes data.

In return the block gives the sequencer, for each channel, the run bit, the descriptor list base address and the current index. It raises one interrupt line per channel.

Top module: `adma_regs`

## Requirements
- R1: After reset every channel reads base 0, current/prefetched/last-valid index 0, position 0, control 0x00 and status 0x01 (halted bit set). All interrupt and run outputs are low.
- R2: Channel c occupies addresses 16*c to 16*c+15, for channels 0 to 2. Base is a word at offset 0x0 and stores bits 31:3, so bits 2:0 read 0. Any access with a channel field of 3 or an unlisted offset/size pair reads 0 and writes nothing.
- R3: A word access at offset 0x4 reads the current index in bits 7:0, the last valid index in bits 15:8 and status in bits 31:16. A word write there loads the last valid index from bits 12:8 and applies write-one-to-clear from bits 20:16.
- R4: The last valid index is a byte at offset 0x5 and keeps its low 5 bits. The current index (byte 0x4), position (half 0x8) and prefetched index (byte 0xA) are read-only to the bus.
- R5: Status is a half at offset 0x6. Writing 1 clears bits 2, 3 and 4. Bits 0 and 1 ignore writes. A set event in the same cycle as a clear of the same bit leaves the bit set.
- R6: The buffer-complete strobe sets status bit 3 only when its completion-interrupt flag is 1. The last-valid strobe sets bit 2. The FIFO-error strobe sets bit 4.
- R7: An advance copies the prefetched index into the current index and increments the prefetched index modulo 32. It sets status bit 1 to 1 when the new current index equals the last valid index, and to 0 otherwise.
- R8: A channel's interrupt is high exactly when (status bit 2 and control bit 2) or (status bit 3 and control bit 4) are both set. Status bit 4 never raises it.
- R9: Control is a byte at offset 0xB; bit 0 is run. A control write with bit 0 set clears status bit 0. A control write with bit 0 clear sets status bit 0.
- R10: A control write with bit 1 set stores the written value, so bit 1 reads 1 for one cycle. At the next edge the block then does the following:
  - zeroes base, current, last valid and prefetched index, and position;
  - clears control bits 0 and 1 and keeps control bits 4:2;
  - sets status bit 0.
- R11: A position-load strobe stores the supplied 16-bit value as the channel's position.
- R12: A write to one channel changes no register of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 write, 0 read |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data, right-justified |
| rdata_o | output | 32 | Read data, right-justified, 0 when no read hits |
| adv_i | input | NCH | Per-channel advance-to-next-descriptor strobe |
| cmpl_i | input | NCH | Per-channel buffer-complete strobe |
| ioc_i | input | NCH | Completion-interrupt flag qualifying cmpl_i |
| lvr_i | input | NCH | Per-channel last-valid-buffer-reached strobe |
| ferr_i | input | NCH | Per-channel FIFO error strobe |
| pos_we_i | input | NCH | Per-channel position load strobe |
| pos_i | input | NCH*POS_W | Position values, channel c at bits c*POS_W upward |
| run_o | output | NCH | Run bit per channel |
| base_o | output | NCH*32 | Descriptor list base per channel |
| civ_o | output | NCH*5 | Current index per channel |
| irq_o | output | NCH | Interrupt per channel |

## Verification
The assertions assume the following about the sequencer and the bus:

- every sequencer strobe is a single-cycle pulse;
- the last valid index is not rewritten in the same cycle as an advance of that channel, so the comparison in R7 uses a settled value;
- bus fields stay stable while req_i is high.

The stimulus drives strobes and bus fields only at the falling edge. Each strobe is held for exactly one rising edge, and a channel's last valid index is never written in the same call that advances it. The only deliberate collision is a set strobe together with a status clear, which R5 defines.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int IDX_W = 5;   // descriptor ring of 32 entries
  localparam int SR_W  = 5;
  localparam int CR_W  = 5;
  localparam int BUS_W = 32;

  localparam logic [3:0] OFF_BASE = 4'h0;
  localparam logic [3:0] OFF_CIV  = 4'h4;
  localparam logic [3:0] OFF_LVI  = 4'h5;
  localparam logic [3:0] OFF_SR   = 4'h6;
  localparam logic [3:0] OFF_POS  = 4'h8;
  localparam logic [3:0] OFF_PIV  = 4'hA;
  localparam logic [3:0] OFF_CR   = 4'hB;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  localparam int SB_HALT = 0;
  localparam int SB_CEL  = 1;
  localparam int SB_LVI  = 2;
  localparam int SB_DONE = 3;
  localparam int SB_FERR = 4;
  localparam logic [SR_W-1:0] SR_W1C   = 5'b11100;
  localparam logic [SR_W-1:0] SR_RESET = 5'b00001;

  localparam int CB_RUN    = 0;
  localparam int CB_RST    = 1;
  localparam int CB_LVIE   = 2;
  localparam int CB_FEIE   = 3;
  localparam int CB_DONEIE = 4;
  localparam logic [CR_W-1:0] CR_KEEP = 5'b11100;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_BASE, ACC_CIV, ACC_PACK, ACC_LVI,
    ACC_SR, ACC_POS, ACC_PIV, ACC_CR
  } acc_e;

  function automatic acc_e acc_of(input logic [3:0] off, input logic [1:0] sz);
    acc_e a;
    case ({off, sz})
      {OFF_BASE, SZ_W}: a = ACC_BASE;
      {OFF_CIV,  SZ_B}: a = ACC_CIV;
      {OFF_CIV,  SZ_W}: a = ACC_PACK;
      {OFF_LVI,  SZ_B}: a = ACC_LVI;
      {OFF_SR,   SZ_H}: a = ACC_SR;
      {OFF_POS,  SZ_H}: a = ACC_POS;
      {OFF_PIV,  SZ_B}: a = ACC_PIV;
      {OFF_CR,   SZ_B}: a = ACC_CR;
      default:          a = ACC_NONE;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/adma_bus_dec.sv
module adma_bus_dec
  import adma_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6,
  localparam int CHF_W = ADDR_W - 4
) (
  input  logic              req_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [CHF_W-1:0]  ch_o,
  output acc_e              acc_o
);
  assign ch_o  = addr_i[ADDR_W-1:4];
  assign acc_o = acc_of(addr_i[3:0], size_i);
  assign hit_o = req_i && (int'(ch_o) < NCH) && (acc_o != ACC_NONE);
endmodule

// File: rtl/adma_chan_regs.sv
module adma_chan_regs
  import adma_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  acc_e             acc_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             adv_i,
  input  logic             cmpl_i,
  input  logic             ioc_i,
  input  logic             lvr_i,
  input  logic             ferr_i,
  input  logic             pos_we_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [BUS_W-1:0] base_o,
  output logic [IDX_W-1:0] civ_o,
  output logic [IDX_W-1:0] lvi_o,
  output logic [IDX_W-1:0] piv_o,
  output logic [SR_W-1:0]  sr_o,
  output logic [CR_W-1:0]  cr_o,
  output logic [POS_W-1:0] pos_o,
  output logic             irq_o
);
  logic [BUS_W-4:0] base_q;
  logic [IDX_W-1:0] civ_q, lvi_q, piv_q;
  logic [SR_W-1:0]  sr_q, sr_n, sr_wbits, sr_clr;
  logic [CR_W-1:0]  cr_q;
  logic [POS_W-1:0] pos_q;
  logic             rst_pend, wr_base, wr_lvi, wr_sr, wr_cr;
  logic [IDX_W-1:0] lvi_wdata;

  assign rst_pend = cr_q[CB_RST];
  assign wr_base  = wr_en_i && (acc_i == ACC_BASE);
  assign wr_lvi   = wr_en_i && ((acc_i == ACC_LVI) || (acc_i == ACC_PACK));
  assign wr_sr    = wr_en_i && ((acc_i == ACC_SR)  || (acc_i == ACC_PACK));
  assign wr_cr    = wr_en_i && (acc_i == ACC_CR);

  assign lvi_wdata = (acc_i == ACC_PACK) ? wdata_i[8 +: IDX_W] : wdata_i[IDX_W-1:0];
  assign sr_wbits  = (acc_i == ACC_PACK) ? wdata_i[16 +: SR_W] : wdata_i[SR_W-1:0];
  assign sr_clr    = wr_sr ? (sr_wbits & SR_W1C) : '0;

  always_comb begin
    sr_n = sr_q & ~sr_clr;
    // set events win over a clear in the same cycle
    sr_n[SB_LVI]  = sr_n[SB_LVI]  | lvr_i;
    sr_n[SB_DONE] = sr_n[SB_DONE] | (cmpl_i & ioc_i);
    sr_n[SB_FERR] = sr_n[SB_FERR] | ferr_i;
    if (adv_i && !rst_pend) sr_n[SB_CEL] = (piv_q == lvi_q);
    if (rst_pend)           sr_n[SB_HALT] = 1'b1;
    else if (wr_cr)         sr_n[SB_HALT] = ~wdata_i[CB_RUN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      civ_q  <= '0;
      lvi_q  <= '0;
      piv_q  <= '0;
      pos_q  <= '0;
      cr_q   <= '0;
      sr_q   <= SR_RESET;
    end else begin
      sr_q <= sr_n;
      if (rst_pend) begin
        base_q <= '0;
        civ_q  <= '0;
        lvi_q  <= '0;
        piv_q  <= '0;
        pos_q  <= '0;
        cr_q   <= cr_q & CR_KEEP;
      end else begin
        if (wr_base)  base_q <= wdata_i[BUS_W-1:3];
        if (wr_lvi)   lvi_q  <= lvi_wdata;
        if (wr_cr)    cr_q   <= wdata_i[CR_W-1:0];
        if (pos_we_i) pos_q  <= pos_i;
        if (adv_i) begin
          civ_q <= piv_q;
          piv_q <= piv_q + IDX_W'(1);
        end
      end
    end
  end

  assign base_o = {base_q, 3'b000};
  assign civ_o  = civ_q;
  assign lvi_o  = lvi_q;
  assign piv_o  = piv_q;
  assign sr_o   = sr_q;
  assign cr_o   = cr_q;
  assign pos_o  = pos_q;
  assign irq_o  = (sr_q[SB_LVI] & cr_q[CB_LVIE]) | (sr_q[SB_DONE] & cr_q[CB_DONEIE]);

  p_adv_idx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !rst_pend) |=> (civ_q == $past(piv_q)) && (piv_q == $past(piv_q) + IDX_W'(1)));
  p_adv_cel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !rst_pend && !wr_lvi) |=> (sr_q[SB_CEL] == (civ_q == lvi_q)));
  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_clr[SB_DONE] && !(cmpl_i && ioc_i)) |=> !sr_q[SB_DONE]);
  p_ro_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sr && !adv_i && !rst_pend) |=> $stable(sr_q[SB_CEL:SB_HALT]));
  p_ioc_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && !ioc_i && !sr_q[SB_DONE]) |=> !sr_q[SB_DONE]);
  p_irq_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cr_q[CB_LVIE] || cr_q[CB_DONEIE]));
  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cr_q[CB_RUN]) |-> sr_q[SB_HALT]);
  p_chan_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pend |=> (base_o == '0) && (civ_q == '0) && (lvi_q == '0) && (piv_q == '0)
                 && (pos_q == '0) && !cr_q[CB_RUN] && !cr_q[CB_RST] && sr_q[SB_HALT]);
  p_keep_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pend |=> (cr_q[CB_DONEIE:CB_LVIE] == $past(cr_q[CB_DONEIE:CB_LVIE])));
endmodule

// File: rtl/adma_rd_fmt.sv
module adma_rd_fmt
  import adma_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  acc_e             acc_i,
  input  logic [BUS_W-1:0] base_i,
  input  logic [IDX_W-1:0] civ_i,
  input  logic [IDX_W-1:0] lvi_i,
  input  logic [IDX_W-1:0] piv_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [BUS_W-1:0] data_o
);
  localparam int IPAD = 8 - IDX_W;

  always_comb begin
    data_o = '0;
    case (acc_i)
      ACC_BASE: data_o = base_i;
      ACC_CIV:  data_o = BUS_W'(civ_i);
      ACC_PACK: data_o = {{(16-SR_W){1'b0}}, sr_i, {IPAD{1'b0}}, lvi_i, {IPAD{1'b0}}, civ_i};
      ACC_LVI:  data_o = BUS_W'(lvi_i);
      ACC_SR:   data_o = BUS_W'(sr_i);
      ACC_POS:  data_o = BUS_W'(pos_i);
      ACC_PIV:  data_o = BUS_W'(piv_i);
      ACC_CR:   data_o = BUS_W'(cr_i);
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6,
  parameter int POS_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [1:0]             size_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BUS_W-1:0]       wdata_i,
  output logic [BUS_W-1:0]       rdata_o,
  input  logic [NCH-1:0]         adv_i,
  input  logic [NCH-1:0]         cmpl_i,
  input  logic [NCH-1:0]         ioc_i,
  input  logic [NCH-1:0]         lvr_i,
  input  logic [NCH-1:0]         ferr_i,
  input  logic [NCH-1:0]         pos_we_i,
  input  logic [NCH*POS_W-1:0]   pos_i,
  output logic [NCH-1:0]         run_o,
  output logic [NCH*BUS_W-1:0]   base_o,
  output logic [NCH*IDX_W-1:0]   civ_o,
  output logic [NCH-1:0]         irq_o
);
  localparam int CHF_W = ADDR_W - 4;

  logic             hit;
  logic [CHF_W-1:0] ch_sel;
  acc_e             acc;
  logic [NCH-1:0]   wr_sel;
  logic [BUS_W-1:0] fmt [NCH];

  adma_bus_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .size_i (size_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .ch_o   (ch_sel),
    .acc_o  (acc)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BUS_W-1:0] base;
    logic [IDX_W-1:0] civ, lvi, piv;
    logic [SR_W-1:0]  sr;
    logic [CR_W-1:0]  cr;
    logic [POS_W-1:0] pos;

    assign wr_sel[c] = hit && we_i && (ch_sel == CHF_W'(c));

    adma_chan_regs #(.POS_W(POS_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_sel[c]),
      .acc_i    (acc),
      .wdata_i  (wdata_i),
      .adv_i    (adv_i[c]),
      .cmpl_i   (cmpl_i[c]),
      .ioc_i    (ioc_i[c]),
      .lvr_i    (lvr_i[c]),
      .ferr_i   (ferr_i[c]),
      .pos_we_i (pos_we_i[c]),
      .pos_i    (pos_i[c*POS_W +: POS_W]),
      .base_o   (base),
      .civ_o    (civ),
      .lvi_o    (lvi),
      .piv_o    (piv),
      .sr_o     (sr),
      .cr_o     (cr),
      .pos_o    (pos),
      .irq_o    (irq_o[c])
    );

    adma_rd_fmt #(.POS_W(POS_W)) u_fmt (
      .acc_i  (acc),
      .base_i (base),
      .civ_i  (civ),
      .lvi_i  (lvi),
      .piv_i  (piv),
      .sr_i   (sr),
      .cr_i   (cr),
      .pos_i  (pos),
      .data_o (fmt[c])
    );

    assign run_o[c]                  = cr[CB_RUN];
    assign base_o[c*BUS_W +: BUS_W]  = base;
    assign civ_o[c*IDX_W +: IDX_W]   = civ;
  end

  assign rdata_o = (hit && !we_i) ? fmt[ch_sel] : '0;

  p_one_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(wr_sel));
  p_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |-> (rdata_o == '0));
endmodule

// File: tb/adma_regs_tb.sv
module adma_regs_tb;
  localparam int NCH = 3;
  localparam int POS_W = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0, we = 0;
  logic [1:0] sz = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NCH-1:0] adv = 0, cmpl = 0, ioc = 0, lvr = 0, ferr = 0, pos_we = 0;
  logic [NCH*POS_W-1:0] pos = 0;
  logic [NCH-1:0] run, irq;
  logic [NCH*32-1:0] base;
  logic [NCH*5-1:0] civ;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adma_regs #(.NCH(NCH), .ADDR_W(6), .POS_W(POS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .adv_i(adv), .cmpl_i(cmpl), .ioc_i(ioc), .lvr_i(lvr), .ferr_i(ferr),
    .pos_we_i(pos_we), .pos_i(pos),
    .run_o(run), .base_o(base), .civ_o(civ), .irq_o(irq)
  );

  typedef struct packed {
    logic        w;
    logic [1:0]  s;
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 6'h10, 32'h1234_567F, 32'h0},         // R2 base, low bits dropped
    '{1'b0, 2'd2, 6'h10, 32'h0, 32'h1234_5678},
    '{1'b1, 2'd0, 6'h15, 32'h0000_00FF, 32'h0},         // R4 lvi keeps 5 bits
    '{1'b0, 2'd0, 6'h15, 32'h0, 32'h0000_001F},
    '{1'b1, 2'd0, 6'h14, 32'h0000_0007, 32'h0},         // R4 civ read-only
    '{1'b0, 2'd0, 6'h14, 32'h0, 32'h0},
    '{1'b1, 2'd0, 6'h1A, 32'h0000_0009, 32'h0},         // R4 piv read-only
    '{1'b0, 2'd0, 6'h1A, 32'h0, 32'h0},
    '{1'b1, 2'd1, 6'h18, 32'h0000_BEEF, 32'h0},         // R4 position read-only
    '{1'b0, 2'd1, 6'h18, 32'h0, 32'h0},
    '{1'b0, 2'd2, 6'h14, 32'h0, 32'h0001_1F00},         // R3 packed read
    '{1'b1, 2'd1, 6'h10, 32'h0000_FFFF, 32'h0},         // R2 wrong size ignored
    '{1'b0, 2'd2, 6'h10, 32'h0, 32'h1234_5678},
    '{1'b0, 2'd0, 6'h10, 32'h0, 32'h0},                 // R2 unlisted read is 0
    '{1'b1, 2'd2, 6'h30, 32'hFFFF_FFFF, 32'h0},         // R2 no channel 3
    '{1'b0, 2'd2, 6'h00, 32'h0, 32'h0},                 // R12 ch0 untouched
    '{1'b1, 2'd2, 6'h24, 32'h0000_0300, 32'h0},         // R3 packed write of lvi
    '{1'b0, 2'd0, 6'h25, 32'h0, 32'h0000_0003}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // ev: 0 adv, 1 cmpl, 2 ioc, 3 lvr, 4 ferr, 5 pos load
  task automatic cyc(input logic rq, input logic [1:0] s, input logic [5:0] a,
                     input logic [31:0] d, input int ch, input logic [5:0] ev);
    @(negedge clk);
    req = rq; we = rq; sz = s; addr = a; wdata = d;
    adv[ch] = ev[0]; cmpl[ch] = ev[1]; ioc[ch] = ev[2];
    lvr[ch] = ev[3]; ferr[ch] = ev[4]; pos_we[ch] = ev[5];
    @(posedge clk);
    #1;
    req = 0; we = 0;
    adv = '0; cmpl = '0; ioc = '0; lvr = '0; ferr = '0; pos_we = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [5:0] a, input logic [31:0] d);
    cyc(1'b1, s, a, d, 0, 6'b0);
  endtask

  task automatic ev(input int ch, input logic [5:0] e);
    cyc(1'b0, 2'd0, 6'h0, 32'h0, ch, e);
  endtask

  task automatic rd(input logic [1:0] s, input logic [5:0] a, output logic [31:0] q);
    @(negedge clk);
    req = 1; we = 0; sz = s; addr = a;
    #2;
    q = rdata;
    req = 0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] s, input logic [5:0] a,
                      input logic [31:0] exp);
    logic [31:0] q;
    rd(s, a, q);
    chk(tag, q, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      rchk("R1 packed", 2'd2, 6'(c*16 + 4), 32'h0001_0000);
      rchk("R1 ctrl", 2'd0, 6'(c*16 + 11), 32'h0);
      rchk("R1 base", 2'd2, 6'(c*16), 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 run", 32'(run), 32'h0);

    // table walk: R2 R3 R4 R12
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) wr(VEC[i].s, VEC[i].a, VEC[i].d);
      else begin
        logic [31:0] q;
        rd(VEC[i].s, VEC[i].a, q);
        chk($sformatf("R2 vector %0d", i), q, VEC[i].e);
      end
    end
    chk("R2 base_o ch1", base[63:32], 32'h1234_5678);

    // R6 status set sources on ch0
    ev(0, 6'b000010);
    rchk("R6 cmpl without ioc", 2'd1, 6'h06, 32'h0001);
    ev(0, 6'b000110);
    rchk("R6 cmpl with ioc", 2'd1, 6'h06, 32'h0009);
    ev(0, 6'b001000);
    rchk("R6 lvr", 2'd1, 6'h06, 32'h000D);
    ev(0, 6'b010000);
    rchk("R6 ferr", 2'd1, 6'h06, 32'h001D);

    // R5 write-one-to-clear
    wr(2'd1, 6'h06, 32'h0003);
    rchk("R5 ro bits", 2'd1, 6'h06, 32'h001D);
    wr(2'd1, 6'h06, 32'h0010);
    rchk("R5 clear ferr", 2'd1, 6'h06, 32'h000D);
    wr(2'd1, 6'h06, 32'h000C);
    rchk("R5 clear two", 2'd1, 6'h06, 32'h0001);
    ev(0, 6'b000110);
    cyc(1'b1, 2'd1, 6'h06, 32'h0008, 0, 6'b000110);
    rchk("R5 set wins", 2'd1, 6'h06, 32'h0009);
    wr(2'd1, 6'h06, 32'h0008);
    rchk("R5 cleared", 2'd1, 6'h06, 32'h0001);

    // R8 interrupt
    wr(2'd0, 6'h0B, 32'h10);
    ev(0, 6'b000110);
    chk("R8 done irq", 32'(irq), 32'h1);
    wr(2'd1, 6'h06, 32'h0008);
    chk("R8 irq cleared", 32'(irq), 32'h0);
    wr(2'd0, 6'h0B, 32'h08);
    ev(0, 6'b010000);
    chk("R8 ferr no irq", 32'(irq), 32'h0);
    wr(2'd0, 6'h0B, 32'h04);
    ev(0, 6'b001000);
    chk("R8 lvi irq", 32'(irq), 32'h1);
    wr(2'd1, 6'h06, 32'h001C);
    chk("R8 irq low", 32'(irq), 32'h0);
    wr(2'd0, 6'h0B, 32'h00);

    // R9 run / halted
    wr(2'd0, 6'h0B, 32'h01);
    rchk("R9 running", 2'd1, 6'h06, 32'h0000);
    chk("R9 run_o", 32'(run), 32'h1);
    wr(2'd0, 6'h0B, 32'h00);
    rchk("R9 halted", 2'd1, 6'h06, 32'h0001);
    chk("R9 run_o low", 32'(run), 32'h0);

    // R7 advance on ch1
    wr(2'd0, 6'h15, 32'h02);
    ev(1, 6'b000001);
    rchk("R7 adv1", 2'd2, 6'h14, 32'h0001_0200);
    ev(1, 6'b000001);
    rchk("R7 adv2", 2'd2, 6'h14, 32'h0001_0201);
    rchk("R7 piv", 2'd0, 6'h1A, 32'h2);
    ev(1, 6'b000001);
    rchk("R7 cel set", 2'd2, 6'h14, 32'h0003_0202);
    chk("R7 civ_o", 32'(civ[9:5]), 32'h2);
    wr(2'd1, 6'h16, 32'h0003);
    rchk("R5 cel read-only", 2'd1, 6'h16, 32'h0003);
    for (int k = 0; k < 29; k++) ev(1, 6'b000001);
    rchk("R7 civ 31", 2'd0, 6'h14, 32'h1F);
    rchk("R7 piv wrap", 2'd0, 6'h1A, 32'h0);
    ev(1, 6'b000001);
    rchk("R7 after wrap", 2'd2, 6'h14, 32'h0001_0200);
    rchk("R7 piv 1", 2'd0, 6'h1A, 32'h1);

    // R11 position load
    pos[31:16] = 16'h1234;
    ev(1, 6'b100000);
    rchk("R11 position", 2'd1, 6'h18, 32'h1234);

    // R10 channel reset on ch1
    wr(2'd0, 6'h1B, 32'h17);
    rchk("R10 bit visible", 2'd0, 6'h1B, 32'h17);
    rchk("R10 ctrl kept", 2'd0, 6'h1B, 32'h14);
    rchk("R10 base", 2'd2, 6'h10, 32'h0);
    rchk("R10 packed", 2'd2, 6'h14, 32'h0001_0000);
    rchk("R10 position", 2'd1, 6'h18, 32'h0);
    rchk("R10 piv", 2'd0, 6'h1A, 32'h0);
    chk("R10 run_o", 32'(run), 32'h0);
    rchk("R12 ch2 lvi kept", 2'd0, 6'h25, 32'h3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule